// File: doc/BRIEF.md
# Configuration Data Loader Registers

This block sits behind a simple register write/read port and lets host software stream device configuration words to a downstream configuration controller. Software programs a mode register, then writes data words. Each accepted data write places the word on a parallel data bus toward the controller. It also emits a burst of clock pulses whose length comes from a count field.

A mode bit steers incoming writes. While the bit is set, every write inside a parameterised address window counts as a data write, and a routing flag tells surrounding logic to send traffic to the configuration path. While the bit is clear, traffic goes to normal fabric and only the data register address loads data. The data bus can be 32 or 64 bits wide. In wide mode a second register supplies the upper half. A write during a running burst is held off with a wait signal until the burst finishes.

Top module: `cfg_loader_regs`

## Requirements
- R1: After reset, the mode register (offset 0x000), the low data register (0x004), the high data register (0x008) and the status register (0x00C) all read 0. The routing flag, `cfg_valid_o` and `cfg_clk_o` are 0.
- R2: The mode register has the following fields: bit 0 is config mode, bit 1 is clock select, bit 2 is wide mode, and bits [15:8] are the pulse count. A write that sets bit 0 while `enable_i` is 0 leaves bit 0 at 0. With `enable_i` at 1, the same write sets it.
- R3: `route_cfg_o` equals the config-mode bit: 1 means the configuration path and 0 means normal fabric.
- R4: When `user_mode_i` and `core_ready_i` are both 1, `clk_sel_o` equals the clock-select bit (1 = internal link clock, 0 = fabric clock). Otherwise `clk_sel_o` is 1.
- R5: A write to the low data register with all four byte enables set does the following. From the next cycle, `cfg_data_o[31:0]` shows the written word. `cfg_valid_o` is high for 2N cycles, where N is the pulse count. `cfg_clk_o` is high for exactly N of those cycles, alternating low then high.
- R6: With a pulse count of 0, a low data write still updates `cfg_data_o[31:0]`, but no pulse and no valid strobe appear.
- R7: A data register write with any byte enable clear is ignored. The register keeps its old value and no burst starts.
- R8: With config mode set, a full write to any address in 0x800..0xFFF acts as a low data write. With config mode clear, such a write changes nothing.
- R9: With wide mode set, `cfg_data_o[63:32]` shows the high data register. With wide mode clear, `cfg_data_o[63:32]` is 0. A high data write never starts a burst.
- R10: Status bit 0 reads 1 while a burst runs. During a burst, a full data write holds `wait_o` at 1 and changes nothing. The write takes effect in the first cycle after the burst ends.
- R11: Status bits [31:1] and mode bits [7:3] and [31:16] read 0. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write request, held while `wait_o` is high |
| req_addr | input | 12 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables of the write |
| rdata_o | output | 32 | Read data for `req_addr` (combinational) |
| wait_o | output | 1 | Data write stalled by a running burst |
| enable_i | input | 1 | Permits config mode to be set |
| user_mode_i | input | 1 | Device is in user mode |
| core_ready_i | input | 1 | Core logic is ready |
| route_cfg_o | output | 1 | 1 steers incoming writes to the configuration path |
| clk_sel_o | output | 1 | Effective clock select |
| cfg_data_o | output | 64 | Data word to the configuration controller |
| cfg_valid_o | output | 1 | High for the whole pulse burst |
| cfg_clk_o | output | 1 | Pulse clock toward the controller, half core rate |

## Verification
The burst path is driven with random data words and random pulse counts from 1 to 6. These show whether the pulse count, the valid length and the data word each follow the count field, rather than staying at one fixed value. Directed writes with partial byte enables, writes into the window with the mode bit both clear and set, and high-word writes in narrow and wide mode show whether the address and byte-enable qualification is applied. A write issued during a burst shows whether it is stalled for the remaining cycles, and a zero count shows whether the data and pulse actions are independent.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   localparam int OFF_MODE = 'h000;
   localparam int OFF_LO   = 'h004;
   localparam int OFF_HI   = 'h008;
   localparam int OFF_STAT = 'h00C;
   localparam int BIT_CFG  = 0;
   localparam int BIT_CLK  = 1;
   localparam int BIT_WIDE = 2;
   localparam int CNT_LSB  = 8;
   localparam int WORD_W   = 32;
endpackage

// File: rtl/cfgl_addr_decode.sv
module cfgl_addr_decode
   import cfgl_pkg::*;
#(
   parameter int AW       = 12,
   parameter int WIN_BASE = 'h800,
   parameter int WIN_LAST = 'hFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_wr,
   input  logic [AW-1:0] req_addr,
   input  logic [3:0]    req_be,
   input  logic          cfg_mode,
   input  logic          busy,
   output logic          wr_mode,
   output logic          wr_lo,
   output logic          wr_hi,
   output logic          wait_o
);
   logic full_be, in_win, lo_hit, hi_hit, data_req;

   assign full_be  = &req_be;
   assign in_win   = (req_addr >= AW'(WIN_BASE)) && (req_addr <= AW'(WIN_LAST));
   assign lo_hit   = (req_addr == AW'(OFF_LO)) || (cfg_mode && in_win);
   assign hi_hit   = (req_addr == AW'(OFF_HI));
   assign data_req = req_wr && full_be && (lo_hit || hi_hit);
   assign wait_o   = data_req && busy;
   assign wr_lo    = req_wr && full_be && lo_hit && !busy;
   assign wr_hi    = req_wr && full_be && hi_hit && !busy;
   assign wr_mode  = req_wr && (req_addr == AW'(OFF_MODE));

   assert_wait_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> busy);
   assert_partial_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(&req_be) |-> (!wr_lo && !wr_hi));
endmodule

// File: rtl/cfgl_mode_regs.sv
module cfgl_mode_regs
   import cfgl_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit HAS_UPPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic [WORD_W-1:0] wdata,
   input  logic [3:0]        be,
   input  logic              enable_i,
   output logic              cfg_mode,
   output logic              clk_sel,
   output logic              wide,
   output logic [CNT_W-1:0]  count
);
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must be 1..8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode <= 1'b0;
         clk_sel  <= 1'b0;
         count    <= '0;
      end else if (wr_mode) begin
         if (be[0]) begin
            cfg_mode <= wdata[BIT_CFG] && enable_i;
            clk_sel  <= wdata[BIT_CLK];
         end
         if (be[1]) count <= wdata[CNT_LSB +: CNT_W];
      end
   end

   if (HAS_UPPER) begin : g_wide
      always_ff @(posedge clk) begin
         if (!rst_n)                wide <= 1'b0;
         else if (wr_mode && be[0]) wide <= wdata[BIT_WIDE];
      end
   end else begin : g_narrow
      assign wide = 1'b0;
   end

   assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mode) |-> $past(enable_i));
endmodule

// File: rtl/cfgl_burst.sv
module cfgl_burst
   import cfgl_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit HAS_UPPER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [CNT_W-1:0]    count,
   input  logic                wide,
   output logic [2*WORD_W-1:0] data_o,
   output logic [WORD_W-1:0]   lo_q,
   output logic [WORD_W-1:0]   hi_q,
   output logic                busy,
   output logic                cfg_clk,
   output logic                cfg_valid
);
   localparam int HC_W = CNT_W + 1;
   logic [HC_W-1:0] half_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q     <= '0;
         half_cnt <= '0;
         cfg_clk  <= 1'b0;
      end else if (wr_lo) begin
         lo_q     <= wdata;
         half_cnt <= {count, 1'b0};
         cfg_clk  <= 1'b0;
      end else if (half_cnt != '0) begin
         half_cnt <= half_cnt - 1'b1;
         cfg_clk  <= ~cfg_clk;
      end
   end

   if (HAS_UPPER) begin : g_hi
      always_ff @(posedge clk) begin
         if (!rst_n)     hi_q <= '0;
         else if (wr_hi) hi_q <= wdata;
      end
      assign data_o[2*WORD_W-1:WORD_W] = wide ? hi_q : '0;
   end else begin : g_no_hi
      assign hi_q = '0;
      assign data_o[2*WORD_W-1:WORD_W] = '0;
   end

   assign data_o[WORD_W-1:0] = lo_q;
   assign busy      = (half_cnt != '0);
   assign cfg_valid = busy;

   assert_clk_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk |-> busy);
   assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && count == '0) |=> !busy);
   assert_stable_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(lo_q));
   assert_hi_no_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !busy) |=> !busy);
endmodule

// File: rtl/cfg_loader_regs.sv
module cfg_loader_regs
   import cfgl_pkg::*;
#(
   parameter int AW        = 12,
   parameter int CNT_W     = 8,
   parameter bit HAS_UPPER = 1'b1,
   parameter int WIN_BASE  = 'h800,
   parameter int WIN_LAST  = 'hFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_wr,
   input  logic [AW-1:0] req_addr,
   input  logic [31:0]   req_wdata,
   input  logic [3:0]    req_be,
   output logic [31:0]   rdata_o,
   output logic          wait_o,
   input  logic          enable_i,
   input  logic          user_mode_i,
   input  logic          core_ready_i,
   output logic          route_cfg_o,
   output logic          clk_sel_o,
   output logic [63:0]   cfg_data_o,
   output logic          cfg_valid_o,
   output logic          cfg_clk_o
);
   if (AW < 4 || WIN_LAST < WIN_BASE || WIN_LAST >= (1 << AW)) begin : g_bad_map
      $error("address map parameters inconsistent");
   end

   logic             wr_mode, wr_lo, wr_hi, busy;
   logic             cfg_mode, clk_sel, wide;
   logic [CNT_W-1:0] count;
   logic [31:0]      lo_q, hi_q;

   cfgl_addr_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_dec (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
      .req_be(req_be), .cfg_mode(cfg_mode), .busy(busy),
      .wr_mode(wr_mode), .wr_lo(wr_lo), .wr_hi(wr_hi), .wait_o(wait_o));

   cfgl_mode_regs #(.CNT_W(CNT_W), .HAS_UPPER(HAS_UPPER)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wdata(req_wdata),
      .be(req_be), .enable_i(enable_i), .cfg_mode(cfg_mode),
      .clk_sel(clk_sel), .wide(wide), .count(count));

   cfgl_burst #(.CNT_W(CNT_W), .HAS_UPPER(HAS_UPPER)) u_burst (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wdata(req_wdata), .count(count), .wide(wide), .data_o(cfg_data_o),
      .lo_q(lo_q), .hi_q(hi_q), .busy(busy), .cfg_clk(cfg_clk_o),
      .cfg_valid(cfg_valid_o));

   assign route_cfg_o = cfg_mode;
   assign clk_sel_o   = (user_mode_i && core_ready_i) ? clk_sel : 1'b1;

   always_comb begin
      rdata_o = '0;
      if (req_addr == AW'(OFF_MODE)) begin
         rdata_o[BIT_CFG]         = cfg_mode;
         rdata_o[BIT_CLK]         = clk_sel;
         rdata_o[BIT_WIDE]        = wide;
         rdata_o[CNT_LSB +: 8]    = 8'(count);
      end else if (req_addr == AW'(OFF_LO)) begin
         rdata_o = lo_q;
      end else if (req_addr == AW'(OFF_HI)) begin
         rdata_o = hi_q;
      end else if (req_addr == AW'(OFF_STAT)) begin
         rdata_o[0] = busy;
      end
   end
endmodule

// File: tb/tb_cfg_loader_regs.sv
`timescale 1ns/1ps
module tb_cfg_loader_regs;
   logic        clk = 1'b0;
   logic        rst_n, req_wr, enable_i, user_mode_i, core_ready_i;
   logic [11:0] req_addr;
   logic [31:0] req_wdata, rdata_o;
   logic [3:0]  req_be;
   logic        wait_o, route_cfg_o, clk_sel_o, cfg_valid_o, cfg_clk_o;
   logic [63:0] cfg_data_o;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cfg_loader_regs dut (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .rdata_o(rdata_o),
      .wait_o(wait_o), .enable_i(enable_i), .user_mode_i(user_mode_i),
      .core_ready_i(core_ready_i), .route_cfg_o(route_cfg_o),
      .clk_sel_o(clk_sel_o), .cfg_data_o(cfg_data_o),
      .cfg_valid_o(cfg_valid_o), .cfg_clk_o(cfg_clk_o));

   function automatic logic [31:0] mode_word(bit cfg, bit cs, bit wd, logic [7:0] cnt);
      return {16'h0, cnt, 5'h0, wd, cs, cfg};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d, logic [3:0] b);
      @(negedge clk);
      req_wr = 1'b1; req_addr = a; req_wdata = d; req_be = b;
      #1;
      while (wait_o) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      req_wr = 1'b0; req_be = 4'h0;
   endtask

   task automatic do_read(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      req_addr = a;
      #1;
      d = rdata_o;
   endtask

   task automatic measure(output int nv, output int nh);
      nv = 0; nh = 0;
      for (int g = 0; g < 2000 && cfg_valid_o; g++) begin
         nv++;
         if (cfg_clk_o) nh++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, d, prev;
      logic [7:0]  n;
      int          nv, nh, wc;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
      enable_i = 1'b0; user_mode_i = 1'b1; core_ready_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      do_read(12'h000, rd); chk("R1 mode", rd, 0);
      do_read(12'h004, rd); chk("R1 lo", rd, 0);
      do_read(12'h008, rd); chk("R1 hi", rd, 0);
      do_read(12'h00C, rd); chk("R1 stat", rd, 0);
      chk("R1 outputs", {route_cfg_o, cfg_valid_o, cfg_clk_o}, 0);

      // R2 gating of config mode
      do_write(12'h000, mode_word(1, 0, 0, 0), 4'hF);
      do_read(12'h000, rd); chk("R2 blocked", rd[0], 0);
      chk("R3 route off", route_cfg_o, 0);
      enable_i = 1'b1;
      do_write(12'h000, mode_word(1, 0, 0, 0), 4'hF);
      do_read(12'h000, rd); chk("R2 allowed", rd[0], 1);
      chk("R3 route on", route_cfg_o, 1);
      do_write(12'h000, mode_word(0, 0, 0, 0), 4'hF);
      chk("R3 route back", route_cfg_o, 0);

      // R4 clock select
      do_write(12'h000, mode_word(0, 1, 0, 0), 4'hF);
      #1; chk("R4 sel1 ready", clk_sel_o, 1);
      do_write(12'h000, mode_word(0, 0, 0, 0), 4'hF);
      #1; chk("R4 sel0 ready", clk_sel_o, 0);
      user_mode_i = 1'b0; #1; chk("R4 no user", clk_sel_o, 1);
      user_mode_i = 1'b1; core_ready_i = 1'b0; #1; chk("R4 no ready", clk_sel_o, 1);
      core_ready_i = 1'b1;

      // R11 reserved bits and status writes
      do_write(12'h000, 32'hFFFF_FFFF, 4'hF);
      do_read(12'h000, rd); chk("R11 mode reserved", rd, 32'h0000_FF07);
      do_write(12'h000, mode_word(0, 0, 0, 0), 4'hF);
      do_write(12'h00C, 32'hFFFF_FFFF, 4'hF);
      do_read(12'h00C, rd); chk("R11 stat", rd, 0);

      // R5 random bursts
      for (int i = 0; i < 20; i++) begin
         n = 8'(1 + ($urandom % 6));
         d = $urandom;
         do_write(12'h000, mode_word(0, 0, 0, n), 4'hF);
         do_write(12'h004, d, 4'hF);
         chk("R5 data", cfg_data_o[31:0], d);
         measure(nv, nh);
         chk("R5 valid len", nv, 2 * n);
         chk("R5 pulses", nh, n);
      end

      // R10 busy status and stall
      do_write(12'h000, mode_word(0, 0, 0, 8'd3), 4'hF);
      do_write(12'h004, 32'hAAAA_0001, 4'hF);
      do_read(12'h00C, rd); chk("R10 busy", rd, 1);
      measure(nv, nh);
      do_write(12'h004, 32'hAAAA_0002, 4'hF);
      @(negedge clk);
      req_wr = 1'b1; req_addr = 12'h004; req_wdata = 32'hBBBB_0003; req_be = 4'hF;
      #1;
      chk("R10 wait high", wait_o, 1);
      chk("R10 data held", cfg_data_o[31:0], 32'hAAAA_0002);
      wc = 0;
      while (wait_o && wc < 100) begin wc++; @(negedge clk); #1; end
      chk("R10 wait cycles", wc, 5);
      @(posedge clk); @(negedge clk);
      req_wr = 1'b0; req_be = 4'h0;
      chk("R10 late write", cfg_data_o[31:0], 32'hBBBB_0003);
      measure(nv, nh);
      chk("R10 late burst", nv, 6);

      // R6 zero count
      do_write(12'h000, mode_word(0, 0, 0, 0), 4'hF);
      do_write(12'h004, 32'h1234_5678, 4'hF);
      chk("R6 data", cfg_data_o[31:0], 32'h1234_5678);
      chk("R6 no valid", cfg_valid_o, 0);
      @(negedge clk); chk("R6 no clk", cfg_clk_o, 0);

      // R7 partial byte enables
      do_write(12'h000, mode_word(0, 0, 0, 8'd2), 4'hF);
      do_write(12'h004, 32'hDEAD_BEEF, 4'h7);
      chk("R7 lo kept", cfg_data_o[31:0], 32'h1234_5678);
      chk("R7 no burst", cfg_valid_o, 0);
      do_read(12'h004, rd); chk("R7 lo read", rd, 32'h1234_5678);

      // R8 window
      do_write(12'h900, 32'h0BAD_0BAD, 4'hF);
      chk("R8 window off", cfg_data_o[31:0], 32'h1234_5678);
      chk("R8 window off burst", cfg_valid_o, 0);
      do_write(12'h000, mode_word(1, 0, 0, 8'd2), 4'hF);
      do_write(12'hFFC, 32'h600D_600D, 4'hF);
      chk("R8 window on", cfg_data_o[31:0], 32'h600D_600D);
      measure(nv, nh);
      chk("R8 window pulses", nh, 2);

      // R9 wide mode
      prev = cfg_data_o[31:0];
      do_write(12'h000, mode_word(0, 0, 1, 8'd4), 4'hF);
      do_write(12'h008, 32'hCAFE_F00D, 4'hF);
      chk("R9 upper wide", cfg_data_o[63:32], 32'hCAFE_F00D);
      chk("R9 no burst on hi", cfg_valid_o, 0);
      chk("R9 lo kept", cfg_data_o[31:0], prev);
      do_write(12'h000, mode_word(0, 0, 0, 8'd4), 4'hF);
      chk("R9 upper narrow", cfg_data_o[63:32], 0);
      do_read(12'h008, rd); chk("R9 hi read", rd, 32'hCAFE_F00D);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule